// File: doc/BRIEF.md
# Branch Direction and Target Predictor

This block sits beside the fetch stage and answers, in the same cycle, two questions about the fetch address: whether the branch there will be taken, and which address to fetch next. It is a direct-mapped table with no tags. The table index is taken from a run of low word-address bits of the program counter. Each slot holds a small direction state and the last taken destination seen for that slot. Branches whose addresses share the index bits share a slot. A collision like this can cost prediction accuracy, but it never produces a wrong result. The pipeline checks the real outcome later and recovers on its own.

When a branch resolves, the pipeline presents its address, its actual outcome and its destination on the update port. The slot is rewritten at the next clock edge. A parameter picks one of two direction policies. In the single-bit policy the slot remembers only the last outcome. In the two-bit policy a saturating counter needs two consecutive wrong guesses before the predicted direction turns.

Top module: `brp_buf`

## Requirements
- R1: After reset every slot predicts not taken with state 00 and a zero destination, so the next address equals the lookup address plus 4.
- R2: When the slot predicts taken, the next address is the slot's stored destination. Otherwise it is the lookup address plus 4.
- R3: The slot is selected by address bits [7:2] (64 slots). Two addresses that differ only outside those bits read and write the same slot.
- R4: In two-bit mode, a taken update raises the state by one and saturates at 11. A not-taken update lowers it by one and saturates at 00. States 11 and 10 predict taken; states 01 and 00 predict not taken.
- R5: In two-bit mode, the predicted direction flips only after two consecutive updates that disagree with it, starting from a saturated state.
- R6: In single-bit mode, the predicted direction after an update equals that update's outcome, so every wrong guess inverts it.
- R7: A taken update stores its destination in the slot. A not-taken update leaves the stored destination unchanged.
- R8: An update changes only the slot its address selects.
- R9: A lookup of a slot in the same cycle as an update to that slot returns the slot's old contents. The new contents are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Fetch address being looked up |
| lk_taken | output | 1 | Predicted direction for lk_pc |
| lk_next_pc | output | 32 | Predicted next fetch address |
| upd_en | input | 1 | Resolved-branch update strobe |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| upd_target | input | 32 | Actual destination of the resolved branch |

## Verification
The bench builds two copies of the block on the same stimulus. One uses the two-bit counter (MODE_BITS=2) and the other uses the single-bit policy (MODE_BITS=1), both with 64 slots starting at bit 2. Because both copies see the same sequence of outcomes, the single-bit copy flipping on each wrong guess can be compared directly against the two-bit copy's hysteresis and its saturation at both ends. The default geometry makes aliasing reachable with an address offset of 0x100, and it leaves neighbouring slots that can be watched for disturbance.

// File: rtl/brp_pkg.sv
package brp_pkg;

    typedef logic [1:0] brp_st_t;

    localparam brp_st_t ST_STRONG_NT = 2'b00;
    localparam brp_st_t ST_WEAK_NT   = 2'b01;
    localparam brp_st_t ST_WEAK_TK   = 2'b10;
    localparam brp_st_t ST_STRONG_TK = 2'b11;

    // Direction read from a state: the upper bit decides.
    function automatic logic st_predicts_taken(brp_st_t s);
        return s[1];
    endfunction

endpackage

// File: rtl/brp_ctr_next.sv
module brp_ctr_next
    import brp_pkg::*;
#(
    parameter int MODE_BITS = 2
) (
    input  brp_st_t cur_st,
    input  logic    taken,
    output brp_st_t nxt_st
);

    generate
        if (MODE_BITS == 1) begin : g_one_bit
            // Remember only the last outcome; stored as 00 or 11.
            always_comb begin
                nxt_st = taken ? ST_STRONG_TK : ST_STRONG_NT;
            end
        end else begin : g_two_bit
            // Saturating up/down counter.
            always_comb begin
                nxt_st = cur_st;
                if (taken) begin
                    if (cur_st != ST_STRONG_TK) nxt_st = cur_st + 2'd1;
                end else begin
                    if (cur_st != ST_STRONG_NT) nxt_st = cur_st - 2'd1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/brp_table.sv
module brp_table
    import brp_pkg::*;
#(
    parameter int ENTRIES   = 64,
    parameter int PC_W      = 32,
    parameter int MODE_BITS = 2,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output brp_st_t          rd_st,
    output logic [PC_W-1:0]  rd_tgt,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken,
    input  logic [PC_W-1:0]  wr_tgt
);

    typedef struct packed {
        logic [ENTRIES-1:0][1:0]      st;
        logic [ENTRIES-1:0][PC_W-1:0] tgt;
    } tbl_t;

    tbl_t    tbl_d, tbl_q;
    brp_st_t upd_nxt_st;

    brp_ctr_next #(.MODE_BITS(MODE_BITS)) u_ctr (
        .cur_st (tbl_q.st[wr_idx]),
        .taken  (wr_taken),
        .nxt_st (upd_nxt_st)
    );

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d.st[wr_idx] = upd_nxt_st;
            if (wr_taken) tbl_d.tgt[wr_idx] = wr_tgt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    // Reads see the registered copy only: old contents during an update.
    assign rd_st  = tbl_q.st[rd_idx];
    assign rd_tgt = tbl_q.tgt[rd_idx];

    // R7
    tgt_on_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_taken && rst_n) |-> tbl_q.tgt[$past(wr_idx)] == $past(wr_tgt));

    // R7
    tgt_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && !wr_taken && rst_n) |-> tbl_q.tgt[$past(wr_idx)] == $past(tbl_q.tgt[wr_idx]));

    generate
        if (MODE_BITS == 1) begin : g_chk1
            // R6
            one_bit_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(wr_en && rst_n) |-> tbl_q.st[$past(wr_idx)][1] == $past(wr_taken));
        end else begin : g_chk2
            // R5
            hyst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(wr_en && rst_n && !wr_taken && tbl_q.st[wr_idx] == ST_STRONG_TK)
                |-> tbl_q.st[$past(wr_idx)] == ST_WEAK_TK);
            // R4
            sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(wr_en && rst_n && !wr_taken && tbl_q.st[wr_idx] == ST_STRONG_NT)
                |-> tbl_q.st[$past(wr_idx)] == ST_STRONG_NT);
        end
    endgenerate

endmodule

// File: rtl/brp_buf.sv
module brp_buf
    import brp_pkg::*;
#(
    parameter int ENTRIES   = 64,
    parameter int PC_W      = 32,
    parameter int IDX_LO    = 2,
    parameter int MODE_BITS = 2,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    output logic [PC_W-1:0] lk_next_pc,
    input  logic            upd_en,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);

    logic [IDX_W-1:0] lk_idx, upd_idx;
    brp_st_t          rd_st;
    logic [PC_W-1:0]  rd_tgt;

    assign lk_idx  = lk_pc[IDX_LO +: IDX_W];
    assign upd_idx = upd_pc[IDX_LO +: IDX_W];

    brp_table #(
        .ENTRIES   (ENTRIES),
        .PC_W      (PC_W),
        .MODE_BITS (MODE_BITS)
    ) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_st    (rd_st),
        .rd_tgt   (rd_tgt),
        .wr_en    (upd_en),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken),
        .wr_tgt   (upd_target)
    );

    always_comb begin
        lk_taken   = st_predicts_taken(rd_st);
        lk_next_pc = lk_taken ? rd_tgt : lk_pc + PC_W'(4);
    end

    // R2
    seq_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_taken |-> lk_next_pc == lk_pc + PC_W'(4));

    // R8
    other_slot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(lk_pc) && !($past(upd_en) && $past(upd_idx) == lk_idx))
        |-> $stable(lk_taken) && $stable(lk_next_pc));

endmodule

// File: tb/brp_buf_tb.sv
module brp_buf_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        upd_en = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic        tk2, tk1;
    logic [31:0] np2, np1;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    brp_buf #(.MODE_BITS(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(tk2), .lk_next_pc(np2),
        .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target));

    brp_buf #(.MODE_BITS(1)) u_dut1 (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(tk1), .lk_next_pc(np1),
        .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic upd(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
        @(negedge clk);
        upd_en = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
        @(posedge clk);
        #1 upd_en = 1'b0;
    endtask

    // Look up pc and compare both copies against expected direction/next pc.
    task automatic look(input string req, input logic [31:0] pc,
                        input logic e2, input logic [31:0] n2,
                        input logic e1, input logic [31:0] n1);
        lk_pc = pc;
        #2;
        chk({req, " dir2"}, {31'd0, tk2}, {31'd0, e2});
        chk({req, " next2"}, np2, n2);
        chk({req, " dir1"}, {31'd0, tk1}, {31'd0, e1});
        chk({req, " next1"}, np1, n1);
    endtask

    task automatic t_reset();
        look("R1 reset", 32'h100, 0, 32'h104, 0, 32'h104);
        look("R1 reset hi", 32'hFC, 0, 32'h100, 0, 32'h100);
    endtask

    task automatic t_train();
        upd(32'h40, 1, 32'h1000);      // 2b: 01, 1b: taken
        look("R4 one taken", 32'h40, 0, 32'h44, 1, 32'h1000);
        upd(32'h40, 1, 32'h1000);      // 2b: 10
        look("R2 R4 weak taken", 32'h40, 1, 32'h1000, 1, 32'h1000);
        upd(32'h40, 1, 32'h1000);      // 2b: 11
        upd(32'h40, 0, 32'h2222);      // 2b: 10 still taken; tgt kept
        look("R5 R6 R7 first miss", 32'h40, 1, 32'h1000, 0, 32'h44);
        upd(32'h40, 0, 32'h3333);      // 2b: 01
        look("R5 second miss", 32'h40, 0, 32'h44, 0, 32'h44);
    endtask

    task automatic t_alias();
        look("R3 alias", 32'h140, 0, 32'h144, 0, 32'h144);
        upd(32'h240, 1, 32'h5000);     // 2b: 10; same slot as 0x40
        look("R3 alias write", 32'h40, 1, 32'h5000, 1, 32'h5000);
        look("R8 neighbour", 32'h44, 0, 32'h48, 0, 32'h48);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 5; i++) upd(32'h80, 1, 32'h7000);
        upd(32'h80, 0, 32'h0);         // 11 -> 10
        look("R4 sat high", 32'h80, 1, 32'h7000, 0, 32'h84);
        for (int i = 0; i < 5; i++) upd(32'h80, 0, 32'h0);
        upd(32'h80, 1, 32'h7100);      // 00 -> 01
        look("R4 sat low", 32'h80, 0, 32'h84, 1, 32'h7100);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        lk_pc = 32'hC0;
        upd_en = 1'b1; upd_pc = 32'hC0; upd_taken = 1'b1; upd_target = 32'h9000;
        #2;
        chk("R9 old dir1", {31'd0, tk1}, 32'd0);
        chk("R9 old next1", np1, 32'hC4);
        @(posedge clk);
        #1 upd_en = 1'b0;
        #2;
        chk("R9 new dir1", {31'd0, tk1}, 32'd1);
        chk("R9 new next1", np1, 32'h9000);
        chk("R9 new dir2", {31'd0, tk2}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_train();
        t_alias();
        t_saturate();
        t_same_cycle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule